// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block turns slot insertion and removal events into state that system software can read. A pulse on the event input carries a 5-bit slot number and a direction. The block records that one change in a pair of 32-bit slot bitmaps, one for added slots and one for removed slots. It also raises a hotplug status bit in a small general-purpose event block. Each new event first wipes both bitmaps, so software only ever sees the most recent change. An insertion flagged as coldplug, meaning a device present from power-on, creates no event at all.

Software reaches the block through a simple single-cycle register port. Writes take effect on the next clock and reads are combinational. The port covers four groups of registers: the two bitmaps, an eject register, a removable-slot mask, and a 4-byte event block. The event block is byte-accessed and holds two write-one-to-clear status bytes followed by two enable bytes. A write to the eject register asks for the slot at the lowest set bit of the written value. If that slot is removable, the block emits a one-cycle eject strobe with the slot index. The removable mask is taken from the static non-hotpluggable slot input at reset. Combining the hotplug condition with other interrupt sources is left to the surrounding logic.

Top module: `hp_event_ctrl`

## Requirements
- R1: After a synchronous reset, both bitmaps read zero, all four event-block bytes read zero, the eject strobe is low, and the removable register reads the inverse of `fixed_mask`.
- R2: The added-slot bitmap at address 0x00 and the removed-slot bitmap at address 0x04 are 32-bit registers that read back the last value written.
- R3: An accepted event sets two things one clock later. Both bitmaps are cleared and bit `evt_slot` is set, in the added bitmap when `evt_insert`=1 or in the removed bitmap when `evt_insert`=0. Bit 1 of status byte 0 (address 0x10) is also set.
- R4: An event with `evt_insert`=1 and `evt_coldplug`=1 changes neither bitmap nor any status bit. A removal is accepted whatever the value of `evt_coldplug`.
- R5: A write to address 0x08 selects slot k, the lowest set bit of the written value. One clock later `eject_stb` is high for exactly one cycle with `eject_slot`=k. Writing zero produces no strobe, and reads of 0x08 return zero.
- R6: An eject request whose selected slot is clear in the removable register produces no strobe.
- R7: The removable register at 0x0C ignores writes. It follows changes of `fixed_mask` only at reset.
- R8: Event-block bytes sit at addresses 0x10 to 0x13 and use `bus_wdata[7:0]`. Bytes 0x10 and 0x11 are status, where writing a one clears that bit. Bytes 0x12 and 0x13 are enable, with plain read/write. Reads are zero-extended to 32 bits.
- R9: `gpe_hp_sts` equals bit 1 of status byte 0. `hp_pending` equals that bit ANDed with bit 1 of enable byte 0x12. Both follow every event-block write and every event.
- R10: When an accepted event and a software write to a bitmap, or a clear of status bit 1, fall in the same cycle, the event's result wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle slot event strobe |
| evt_slot | input | 5 | Slot index of the event |
| evt_insert | input | 1 | 1 = insertion, 0 = removal |
| evt_coldplug | input | 1 | Insertion belongs to power-on population |
| fixed_mask | input | 32 | Slots that may not be hot-removed |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 5 | Register address (bit 4 selects the event block) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| gpe_hp_sts | output | 1 | Hotplug status bit |
| hp_pending | output | 1 | Hotplug status gated by its enable |
| eject_stb | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot index of the eject request |

## Verification
The hardest situation to reach is a collision: an event arriving in the same clock as a software write that targets the same state. Two cases matter, a write to a bitmap and a write-one-to-clear of the hotplug status bit. The stimulus task drives the event inputs and the register port together in one cycle, so both collisions are produced on purpose. The reset value of the removable register is also checked across a mid-run change of `fixed_mask` and a second reset.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int unsigned HP_SLOTS    = 32;
    localparam int unsigned HP_SLOT_W   = $clog2(HP_SLOTS);
    localparam int unsigned HP_DATA_W   = 32;
    localparam int unsigned HP_ADDR_W   = 5;
    localparam int unsigned HP_GPE_LEN  = 4;
    localparam int unsigned HP_GPE_BIT  = 1;

    typedef enum logic [1:0] {
        HW_UP    = 2'd0,
        HW_DOWN  = 2'd1,
        HW_EJECT = 2'd2,
        HW_RMV   = 2'd3
    } hp_word_e;

    typedef struct packed {
        logic                 found;
        logic [HP_SLOT_W-1:0] idx;
    } hp_lowest_t;

    function automatic hp_lowest_t hp_lowest(input logic [HP_DATA_W-1:0] v);
        hp_lowest_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = HP_DATA_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = HP_SLOT_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hp_slot_tracker.sv
module hp_slot_tracker
    import hp_pkg::*;
#(
    parameter int unsigned SLOTS  = HP_SLOTS,
    parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_fire,
    input  logic              evt_insert,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic              wr_up,
    input  logic              wr_down,
    input  logic [SLOTS-1:0]  wdata,
    output logic [SLOTS-1:0]  up_q,
    output logic [SLOTS-1:0]  down_q
);

    logic [SLOTS-1:0] slot_bit;

    always_comb begin
        slot_bit = '0;
        slot_bit[evt_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q   <= '0;
            down_q <= '0;
        end else if (evt_fire) begin
            up_q   <= evt_insert ? slot_bit : '0;
            down_q <= evt_insert ? '0 : slot_bit;
        end else begin
            if (wr_up)   up_q   <= wdata;
            if (wr_down) down_q <= wdata;
        end
    end

    // R3
    evt_single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        evt_fire |=> $countones(up_q | down_q) == 1);

    // R2
    bitmap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_fire && !wr_up && !wr_down |=> $stable(up_q) && $stable(down_q));

endmodule

// File: rtl/hp_eject_unit.sv
module hp_eject_unit
    import hp_pkg::*;
#(
    parameter int unsigned SLOTS  = HP_SLOTS,
    parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_eject,
    input  logic [HP_DATA_W-1:0] wdata,
    input  logic [SLOTS-1:0]     rmv_mask,
    output logic                 stb_q,
    output logic [SLOT_W-1:0]    slot_q
);

    hp_lowest_t lo;
    logic       allowed;

    always_comb begin
        lo      = hp_lowest(wdata);
        allowed = wr_eject && lo.found && (int'(lo.idx) < SLOTS) &&
                  rmv_mask[lo.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            slot_q <= '0;
        end else begin
            stb_q <= allowed;
            if (allowed) slot_q <= SLOT_W'(lo.idx);
        end
    end

    // R6
    eject_removable_chk: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> rmv_mask[slot_q]);

    // R5
    eject_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_eject && wdata == '0 |=> !stb_q);

endmodule

// File: rtl/hp_gpe_block.sv
module hp_gpe_block
    import hp_pkg::*;
#(
    parameter int unsigned BYTES  = HP_GPE_LEN,
    parameter int unsigned HP_BIT = HP_GPE_BIT,
    parameter int unsigned SEL_W  = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    input  logic             hp_set,
    output logic [7:0]       rd8,
    output logic             hp_sts,
    output logic             hp_pending
);

    localparam int unsigned STS_N = BYTES / 2;
    localparam int unsigned EN_N  = BYTES - STS_N;

    logic [STS_N*8-1:0] sts_q, sts_d;
    logic [EN_N*8-1:0]  en_q,  en_d;

    always_comb begin
        sts_d = sts_q;
        en_d  = en_q;
        for (int i = 0; i < STS_N; i++) begin
            if (wr && int'(sel) == i)
                sts_d[i*8 +: 8] = sts_q[i*8 +: 8] & ~wdata;
        end
        for (int j = 0; j < EN_N; j++) begin
            if (wr && int'(sel) == STS_N + j)
                en_d[j*8 +: 8] = wdata;
        end
        if (hp_set) sts_d[HP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
        end
    end

    always_comb begin
        rd8 = '0;
        for (int i = 0; i < STS_N; i++)
            if (int'(sel) == i) rd8 = sts_q[i*8 +: 8];
        for (int j = 0; j < EN_N; j++)
            if (int'(sel) == STS_N + j) rd8 = en_q[j*8 +: 8];
    end

    assign hp_sts     = sts_q[HP_BIT];
    assign hp_pending = sts_q[HP_BIT] & en_q[HP_BIT];

    // R3
    hp_set_chk: assert property (@(posedge clk) disable iff (rst)
        hp_set |=> hp_sts);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr && sel == '0 && wdata[HP_BIT] && !hp_set |=> !hp_sts);

endmodule

// File: rtl/hp_event_ctrl.sv
module hp_event_ctrl
    import hp_pkg::*;
#(
    parameter int unsigned SLOTS   = HP_SLOTS,
    parameter int unsigned SLOT_W  = $clog2(SLOTS),
    parameter int unsigned ADDR_W  = HP_ADDR_W,
    parameter int unsigned GPE_LEN = HP_GPE_LEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_valid,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic                 evt_insert,
    input  logic                 evt_coldplug,
    input  logic [SLOTS-1:0]     fixed_mask,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [HP_DATA_W-1:0] bus_wdata,
    output logic [HP_DATA_W-1:0] bus_rdata,
    output logic                 gpe_hp_sts,
    output logic                 hp_pending,
    output logic                 eject_stb,
    output logic [SLOT_W-1:0]    eject_slot
);

    localparam int unsigned GSEL_W = $clog2(GPE_LEN);

    logic             in_gpe;
    hp_word_e         word;
    logic             evt_fire;
    logic             wr_up, wr_down, wr_eject, wr_gpe;
    logic [SLOTS-1:0] up_q, down_q, rmv_q;
    logic [7:0]       gpe_rd8;

    always_comb begin
        in_gpe   = bus_addr[ADDR_W-1];
        word     = hp_word_e'(bus_addr[3:2]);
        evt_fire = evt_valid && !(evt_insert && evt_coldplug);
        wr_up    = bus_wr && !in_gpe && word == HW_UP;
        wr_down  = bus_wr && !in_gpe && word == HW_DOWN;
        wr_eject = bus_wr && !in_gpe && word == HW_EJECT;
        wr_gpe   = bus_wr && in_gpe;
    end

    always_ff @(posedge clk) begin
        if (rst) rmv_q <= ~fixed_mask;
    end

    hp_slot_tracker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) trk_i (
        .clk        (clk),
        .rst        (rst),
        .evt_fire   (evt_fire),
        .evt_insert (evt_insert),
        .evt_slot   (evt_slot),
        .wr_up      (wr_up),
        .wr_down    (wr_down),
        .wdata      (bus_wdata[SLOTS-1:0]),
        .up_q       (up_q),
        .down_q     (down_q)
    );

    hp_eject_unit #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) ej_i (
        .clk      (clk),
        .rst      (rst),
        .wr_eject (wr_eject),
        .wdata    (bus_wdata),
        .rmv_mask (rmv_q),
        .stb_q    (eject_stb),
        .slot_q   (eject_slot)
    );

    hp_gpe_block #(.BYTES(GPE_LEN), .HP_BIT(HP_GPE_BIT)) gpe_i (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_gpe),
        .sel        (bus_addr[GSEL_W-1:0]),
        .wdata      (bus_wdata[7:0]),
        .hp_set     (evt_fire),
        .rd8        (gpe_rd8),
        .hp_sts     (gpe_hp_sts),
        .hp_pending (hp_pending)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_gpe) begin
            bus_rdata[7:0] = gpe_rd8;
        end else begin
            unique case (word)
                HW_UP:    bus_rdata[SLOTS-1:0] = up_q;
                HW_DOWN:  bus_rdata[SLOTS-1:0] = down_q;
                HW_EJECT: bus_rdata = '0;
                HW_RMV:   bus_rdata[SLOTS-1:0] = rmv_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R4
    cold_insert_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_insert && evt_coldplug && !bus_wr |=>
        $stable(up_q) && $stable(down_q) && $stable(gpe_hp_sts));

    // R7
    rmv_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !in_gpe && word == HW_RMV |=> $stable(rmv_q));

    // R10
    evt_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
        evt_fire && evt_insert && wr_up |=> $countones(up_q) == 1);

endmodule

// File: tb/hp_event_ctrl_tb.sv
`timescale 1ns/1ps
module hp_event_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_slot = '0;
    logic        evt_insert = 1'b0;
    logic        evt_coldplug = 1'b0;
    logic [31:0] fixed_mask = 32'h0000_0011;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        gpe_hp_sts, hp_pending, eject_stb;
    logic [4:0]  eject_slot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hp_event_ctrl dut_i (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_slot(evt_slot),
        .evt_insert(evt_insert), .evt_coldplug(evt_coldplug),
        .fixed_mask(fixed_mask), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpe_hp_sts(gpe_hp_sts),
        .hp_pending(hp_pending), .eject_stb(eject_stb), .eject_slot(eject_slot)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [31:0] m_up, m_down, m_rmv;
    bit        m_sts, m_en, m_stb, m_live;
    bit [4:0]  m_slot;

    always @(posedge clk) begin
        if (rst) begin
            m_up = 0; m_down = 0; m_rmv = ~fixed_mask;
            m_sts = 0; m_en = 0; m_stb = 0; m_live = 1;
        end else begin
            int first;
            first = -1;
            m_stb = 0;
            if (bus_wr && bus_addr == 5'h08) begin
                for (int k = 31; k >= 0; k--) if (bus_wdata[k]) first = k;
                if (first >= 0 && m_rmv[first]) begin
                    m_stb = 1; m_slot = 5'(first);
                end
            end
            if (bus_wr && bus_addr == 5'h00) m_up = bus_wdata;
            if (bus_wr && bus_addr == 5'h04) m_down = bus_wdata;
            if (bus_wr && bus_addr == 5'h10 && bus_wdata[1]) m_sts = 0;
            if (bus_wr && bus_addr == 5'h12) m_en = bus_wdata[1];
            if (evt_valid && !(evt_insert && evt_coldplug)) begin
                m_up = 0; m_down = 0;
                if (evt_insert) m_up[evt_slot] = 1'b1;
                else            m_down[evt_slot] = 1'b1;
                m_sts = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && m_live && !done) begin
            check("R9 status bit", {31'b0, gpe_hp_sts}, {31'b0, m_sts});
            check("R9 pending", {31'b0, hp_pending}, {31'b0, m_sts & m_en});
            check("R5 eject strobe", {31'b0, eject_stb}, {31'b0, m_stb});
            if (m_stb) check("R5 eject slot", {27'b0, eject_slot}, {27'b0, m_slot});
        end
    end

    // one cycle: optional write and optional event together
    task automatic cyc(input bit w, input logic [4:0] a, input logic [31:0] d,
                       input bit ev, input logic [4:0] s, input bit ins, input bit cold);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        evt_valid = ev; evt_slot = s; evt_insert = ins; evt_coldplug = cold;
        @(negedge clk);
        bus_wr = 0; evt_valid = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic ev(input logic [4:0] s, input bit ins, input bit cold);
        cyc(0, 0, 0, 1, s, ins, cold);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(5'h00, 32'h0, "R1 up");
        rd(5'h04, 32'h0, "R1 down");
        rd(5'h0C, 32'hFFFF_FFEE, "R1 removable");
        for (int b = 16; b < 20; b++) rd(5'(b), 32'h0, "R1 gpe byte");
        check("R1 eject low", {31'b0, eject_stb}, 32'h0);
        // R2 bitmap read/write
        wr(5'h00, 32'hA5A5_0001); rd(5'h00, 32'hA5A5_0001, "R2 up rw");
        wr(5'h04, 32'h0000_F00D); rd(5'h04, 32'h0000_F00D, "R2 down rw");
        // R3 insertion
        ev(5'd7, 1, 0);
        rd(5'h00, 32'h0000_0080, "R3 up after insert");
        rd(5'h04, 32'h0, "R3 down wiped");
        rd(5'h10, 32'h2, "R3 status set");
        // R8 / R9 enables and clear
        wr(5'h12, 32'h02); rd(5'h12, 32'h02, "R8 enable rw");
        check("R9 pending high", {31'b0, hp_pending}, 32'h1);
        wr(5'h13, 32'h5A); rd(5'h13, 32'h5A, "R8 enable byte 3");
        wr(5'h10, 32'h02); rd(5'h10, 32'h0, "R8 w1c");
        check("R9 pending low", {31'b0, hp_pending}, 32'h0);
        // R3 removal
        ev(5'd31, 0, 0);
        rd(5'h04, 32'h8000_0000, "R3 down after remove");
        rd(5'h00, 32'h0, "R3 up wiped");
        wr(5'h10, 32'hFD); rd(5'h10, 32'h2, "R8 w1c zero bit keeps");
        wr(5'h11, 32'hFF); rd(5'h11, 32'h0, "R8 status byte1");
        wr(5'h10, 32'hFF); rd(5'h10, 32'h0, "R8 w1c all");
        // R4 coldplug
        ev(5'd3, 1, 1);
        rd(5'h00, 32'h0, "R4 cold insert up");
        rd(5'h04, 32'h8000_0000, "R4 cold insert down");
        rd(5'h10, 32'h0, "R4 cold insert status");
        ev(5'd2, 0, 1);
        rd(5'h04, 32'h0000_0004, "R4 cold removal accepted");
        rd(5'h10, 32'h2, "R4 cold removal status");
        wr(5'h10, 32'h02);
        // R5 eject
        wr(5'h08, 32'h0000_0C00);
        check("R5 strobe", {31'b0, eject_stb}, 32'h1);
        check("R5 slot", {27'b0, eject_slot}, 32'd10);
        @(negedge clk);
        check("R5 single pulse", {31'b0, eject_stb}, 32'h0);
        rd(5'h08, 32'h0, "R5 eject reads zero");
        wr(5'h08, 32'h0);
        check("R5 zero write no strobe", {31'b0, eject_stb}, 32'h0);
        // R6 fixed slots
        wr(5'h08, 32'h0000_0011);
        check("R6 slot0 fixed", {31'b0, eject_stb}, 32'h0);
        wr(5'h08, 32'h0000_0010);
        check("R6 slot4 fixed", {31'b0, eject_stb}, 32'h0);
        wr(5'h08, 32'h8000_0000);
        check("R5 slot31", {27'b0, eject_slot}, 32'd31);
        // R7 removable
        wr(5'h0C, 32'h0); rd(5'h0C, 32'hFFFF_FFEE, "R7 write ignored");
        fixed_mask = 32'h0000_00FF;
        @(negedge clk); rd(5'h0C, 32'hFFFF_FFEE, "R7 no live follow");
        do_reset();
        rd(5'h0C, 32'hFFFF_FF00, "R7 reload at reset");
        rd(5'h04, 32'h0, "R1 down after reset");
        wr(5'h08, 32'h0000_0100);
        check("R6 slot8 allowed", {27'b0, eject_slot}, 32'd8);
        // R10 collisions
        cyc(1, 5'h00, 32'hFFFF_FFFF, 1, 5'd5, 1, 0);
        rd(5'h00, 32'h0000_0020, "R10 event over up write");
        cyc(1, 5'h10, 32'h02, 1, 5'd6, 0, 0);
        rd(5'h10, 32'h2, "R10 event over w1c");
        rd(5'h04, 32'h0000_0040, "R10 removal bitmap");
        cyc(1, 5'h04, 32'h1234_5678, 1, 5'd9, 1, 0);
        rd(5'h04, 32'h0, "R10 event over down write");
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule